// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the hardware side of a CPU's interrupt call and return. When the interrupt controller raises a request while the CPU's global enable flag is set, the sequencer captures the current program counter, the flag byte and the supplied vector in one cycle. Over a fixed window of cycles it then pushes the program counter high byte, the low byte and the flags onto a byte-wide stack that grows upward. It commands the CPU to clear its flag register, which turns off further interrupts. It returns a one-cycle acknowledge to the controller. In the last cycle it loads the program counter with the vector.

A return command reverses the entry. The block pops flags, program counter low byte and program counter high byte from the stack in three cycles. In the following cycle it writes the flags and the program counter back to the CPU. If the enable flag was set before entry, this write turns interrupts back on. A handler that sets the enable flag again can be interrupted, and the stack then holds one three-byte frame per level. The stack memory is external and is read combinationally at the address the block drives. The block keeps the stack pointer itself.

Top module: `irq_seq`

## Requirements
- R1: After reset, busy_o, done_o, irq_ack_o, stk_we_o, pc_we_o and flags_we_o are low and sp_o is 0.
- R2: In an idle cycle with reti_i low, a request is accepted only if irq_req_i is high and flags_i bit IE_BIT (bit 0 by default) is 1. A request with that bit at 0 leaves every output and sp_o unchanged.
- R3: In entry cycles 0, 1 and 2 (cycle 0 is the first cycle after acceptance), stk_we_o is high. The block writes the captured program counter bits [15:8], then bits [7:0], then the captured flags, to addresses sp, sp+1 and sp+2, where sp is the pointer at acceptance. sp_o ends 3 higher.
- R4: In entry cycle 3, flags_we_o is high with flags_o equal to 0, which clears the global enable.
- R5: busy_o is high for exactly ENTRY_CYCLES (13) consecutive cycles from entry cycle 0. In the last of these cycles, pc_we_o and done_o are high and pc_o equals the vector captured at acceptance.
- R6: irq_ack_o is high for exactly one cycle per entry, in entry cycle 0.
- R7: While busy_o is high, irq_req_i and reti_i are ignored. No extra stack write, acknowledge or pointer change results.
- R8: When reti_i is high in an idle cycle, three pop cycles follow, with stk_we_o low and addresses sp-1, sp-2 and sp-3. The bytes read there are the flags, program counter bits [7:0] and bits [15:8]. In a fourth cycle done_o, flags_we_o and pc_we_o are high with the restored values. busy_o is high for all four cycles, and sp_o ends 3 lower.
- R9: When reti_i and an enabled request are both present in an idle cycle, the return is started and no acknowledge is given.
- R10: Nested entries push their frames above earlier frames. Returns restore the frames in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 1 | Interrupt request from the controller |
| irq_vec_i | input | 2*BYTE_W | Handler vector address |
| irq_ack_o | output | 1 | One-cycle acknowledge to the controller |
| reti_i | input | 1 | Return-from-interrupt command |
| pc_i | input | 2*BYTE_W | Current program counter |
| flags_i | input | BYTE_W | Current flag register |
| pc_we_o | output | 1 | Program counter load strobe |
| pc_o | output | 2*BYTE_W | Program counter load value |
| flags_we_o | output | 1 | Flag register load strobe |
| flags_o | output | BYTE_W | Flag register load value |
| stk_we_o | output | 1 | Stack write strobe |
| stk_addr_o | output | SP_W | Stack address |
| stk_wdata_o | output | BYTE_W | Stack write byte |
| stk_rdata_i | input | BYTE_W | Stack read byte at stk_addr_o, same cycle |
| sp_o | output | SP_W | Stack pointer, next free byte |
| busy_o | output | 1 | Entry or return sequence in progress |
| done_o | output | 1 | Last cycle of an entry or return |

## Verification
The bench builds the block with BYTE_W 8, ENTRY_CYCLES 13 and IE_BIT 0, so the full 13-cycle entry window is checked cycle by cycle. It narrows SP_W to 6, which keeps the bench's stack model at 64 bytes. The bench still nests two levels with six live bytes and checks the addresses. The vectors use program counters of all ones and all zeros and flag bytes that differ from bit 0. These expose swapped byte order in the push and pop paths and a flag clear that leaves stray bits.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENTRY = 2'd1,
    ST_POP   = 2'd2,
    ST_RDONE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int unsigned ENTRY_CYCLES = 13,
  parameter int unsigned STEP_W       = $clog2(ENTRY_CYCLES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              ie_i,
  input  logic              reti_i,
  output seq_state_e        state_o,
  output logic [STEP_W-1:0] step_o,
  output logic              start_entry_o,
  output logic              start_ret_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(ENTRY_CYCLES - 1);
  localparam logic [STEP_W-1:0] LAST_POP  = STEP_W'(2);

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;

  // return wins over a simultaneous request
  assign start_ret_o   = (state_q == ST_IDLE) && reti_i;
  assign start_entry_o = (state_q == ST_IDLE) && !reti_i && req_i && ie_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          step_q <= '0;
          if (start_ret_o)        state_q <= ST_POP;
          else if (start_entry_o) state_q <= ST_ENTRY;
        end
        ST_ENTRY: begin
          if (step_q == LAST_STEP) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_POP: begin
          if (step_q == LAST_POP) begin
            state_q <= ST_RDONE;
            step_q  <= '0;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign step_o  = step_q;
endmodule

// File: rtl/irq_seq_stack.sv
module irq_seq_stack #(
  parameter int unsigned SP_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  output logic [SP_W-1:0] sp_o,
  output logic [SP_W-1:0] addr_o
);
  logic [SP_W-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (push_i) sp_q <= sp_q + 1'b1;
    else if (pop_i)  sp_q <= sp_q - 1'b1;
  end

  // pointer marks next free byte; pop reads the byte below it
  assign addr_o = pop_i ? sp_q - 1'b1 : sp_q;
  assign sp_o   = sp_q;

  p_push_grow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> sp_o == SP_W'($past(sp_o) + 1'b1));
  p_pop_shrink_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> sp_o == SP_W'($past(sp_o) - 1'b1));
  p_push_pop_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned BYTE_W       = 8,
  parameter int unsigned SP_W         = 8,
  parameter int unsigned ENTRY_CYCLES = 13,
  parameter int unsigned IE_BIT       = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  irq_req_i,
  input  logic [2*BYTE_W-1:0]   irq_vec_i,
  output logic                  irq_ack_o,
  input  logic                  reti_i,
  input  logic [2*BYTE_W-1:0]   pc_i,
  input  logic [BYTE_W-1:0]     flags_i,
  output logic                  pc_we_o,
  output logic [2*BYTE_W-1:0]   pc_o,
  output logic                  flags_we_o,
  output logic [BYTE_W-1:0]     flags_o,
  output logic                  stk_we_o,
  output logic [SP_W-1:0]       stk_addr_o,
  output logic [BYTE_W-1:0]     stk_wdata_o,
  input  logic [BYTE_W-1:0]     stk_rdata_i,
  output logic [SP_W-1:0]       sp_o,
  output logic                  busy_o,
  output logic                  done_o
);
  localparam int unsigned PC_W   = 2 * BYTE_W;
  localparam int unsigned STEP_W = $clog2(ENTRY_CYCLES);
  localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(ENTRY_CYCLES - 1);
  localparam logic [STEP_W-1:0] CLEAR_STEP = STEP_W'(3);

  seq_state_e        state;
  logic [STEP_W-1:0] step;
  logic              start_entry, start_ret;
  logic              push, pop;
  logic [PC_W-1:0]   pc_q, vec_q;
  logic [BYTE_W-1:0] flg_q;

  irq_seq_ctrl #(.ENTRY_CYCLES(ENTRY_CYCLES), .STEP_W(STEP_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (irq_req_i),
    .ie_i         (flags_i[IE_BIT]),
    .reti_i       (reti_i),
    .state_o      (state),
    .step_o       (step),
    .start_entry_o(start_entry),
    .start_ret_o  (start_ret)
  );

  assign push = (state == ST_ENTRY) && (step < CLEAR_STEP);
  assign pop  = (state == ST_POP);

  irq_seq_stack #(.SP_W(SP_W)) u_stack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(push),
    .pop_i (pop),
    .sp_o  (sp_o),
    .addr_o(stk_addr_o)
  );

  // frame registers: captured on entry, refilled by pops on return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      flg_q <= '0;
      vec_q <= '0;
    end else if (start_entry) begin
      pc_q  <= pc_i;
      flg_q <= flags_i;
      vec_q <= irq_vec_i;
    end else if (pop) begin
      case (step)
        STEP_W'(0): flg_q             <= stk_rdata_i;
        STEP_W'(1): pc_q[BYTE_W-1:0]  <= stk_rdata_i;
        default:    pc_q[PC_W-1:BYTE_W] <= stk_rdata_i;
      endcase
    end
  end

  always_comb begin
    case (step)
      STEP_W'(0): stk_wdata_o = pc_q[PC_W-1:BYTE_W];
      STEP_W'(1): stk_wdata_o = pc_q[BYTE_W-1:0];
      default:    stk_wdata_o = flg_q;
    endcase
  end

  assign stk_we_o   = push;
  assign irq_ack_o  = (state == ST_ENTRY) && (step == '0);
  assign flags_we_o = ((state == ST_ENTRY) && (step == CLEAR_STEP)) || (state == ST_RDONE);
  assign flags_o    = (state == ST_RDONE) ? flg_q : '0;
  assign pc_we_o    = ((state == ST_ENTRY) && (step == LAST_STEP)) || (state == ST_RDONE);
  assign pc_o       = (state == ST_RDONE) ? pc_q : vec_q;
  assign done_o     = pc_we_o;
  assign busy_o     = (state != ST_IDLE);

  p_accept_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && irq_req_i && flags_i[IE_BIT] && !reti_i) |=> irq_ack_o);
  p_ack_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> !irq_ack_o);
  p_ack_in_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> (busy_o && stk_we_o && !done_o));
  p_flags_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_we_o && !done_o) |-> (flags_o == '0));
  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  p_ret_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && reti_i) |=> (busy_o && !stk_we_o && !irq_ack_o));
endmodule

// File: tb/irq_seq_tb_top.sv
module irq_seq_tb_top;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SP_W   = 6;
  localparam int unsigned NCYC   = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_req = 1'b0, reti = 1'b0;
  logic [15:0] irq_vec = '0, pc_in = '0;
  logic [7:0]  flags_in = '0;
  logic        irq_ack, pc_we, flags_we, stk_we, busy, done;
  logic [15:0] pc_out;
  logic [7:0]  flags_out, stk_wdata, stk_rdata;
  logic [SP_W-1:0] stk_addr, sp;
  logic [7:0] mem [2**SP_W];
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  irq_seq #(.BYTE_W(BYTE_W), .SP_W(SP_W), .ENTRY_CYCLES(NCYC), .IE_BIT(0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req), .irq_vec_i(irq_vec),
    .irq_ack_o(irq_ack), .reti_i(reti), .pc_i(pc_in), .flags_i(flags_in),
    .pc_we_o(pc_we), .pc_o(pc_out), .flags_we_o(flags_we), .flags_o(flags_out),
    .stk_we_o(stk_we), .stk_addr_o(stk_addr), .stk_wdata_o(stk_wdata),
    .stk_rdata_i(stk_rdata), .sp_o(sp), .busy_o(busy), .done_o(done)
  );

  always_ff @(posedge clk) if (stk_we) mem[stk_addr] <= stk_wdata;
  assign stk_rdata = mem[stk_addr];

  // {pc, flags (bit 0 set), vector}
  localparam logic [39:0] VEC_TAB [4] = '{
    {16'h1234, 8'h01, 16'h0008},
    {16'hABCD, 8'hFF, 16'h003C},
    {16'h0000, 8'h01, 16'hFFFC},
    {16'hFFFF, 8'h55, 16'h0020}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_entry(input logic [15:0] pc, input logic [7:0] fl, input logic [15:0] vec,
                          input logic [SP_W-1:0] sp0, input bit noise);
    @(negedge clk);
    pc_in = pc; flags_in = fl; irq_vec = vec; irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    for (int k = 0; k < NCYC; k++) begin
      if (noise && k == 4) begin irq_req = 1'b1; reti = 1'b1; end
      if (noise && k == 10) begin irq_req = 1'b0; reti = 1'b0; end
      chk("R5", "busy", busy, 1);
      chk("R6", "ack", irq_ack, (k == 0));
      chk("R3", "stk_we", stk_we, (k < 3));
      if (k < 3) begin
        chk("R3", "addr", stk_addr, sp0 + k);
        chk("R3", "wdata", stk_wdata, (k == 0) ? pc[15:8] : (k == 1) ? pc[7:0] : fl);
      end
      chk("R4", "flags_we", flags_we, (k == 3));
      if (k == 3) chk("R4", "flags_o", flags_out, 0);
      chk("R5", "pc_we", pc_we, (k == NCYC - 1));
      chk("R5", "done", done, (k == NCYC - 1));
      if (k == NCYC - 1) chk("R5", "pc_o", pc_out, vec);
      if (noise && k > 4) chk("R7", "no extra push", stk_we, 0);
      @(negedge clk);
    end
    chk("R5", "busy end", busy, 0);
    chk("R3", "sp after entry", sp, SP_W'(sp0 + 3));
  endtask

  task automatic do_ret(input logic [SP_W-1:0] sp0, input logic [15:0] pc, input logic [7:0] fl,
                        input bit both);
    @(negedge clk);
    reti = 1'b1;
    if (both) begin irq_req = 1'b1; flags_in = 8'h01; end
    @(negedge clk);
    reti = 1'b0; irq_req = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R8", "busy", busy, 1);
      chk(both ? "R9" : "R8", "ack", irq_ack, 0);
      chk("R8", "stk_we", stk_we, 0);
      if (k < 3) begin
        chk("R8", "pop addr", stk_addr, SP_W'(sp0 - 1 - k));
        chk("R8", "done early", done, 0);
      end else begin
        chk("R8", "done", done, 1);
        chk("R8", "pc_we", pc_we, 1);
        chk("R8", "flags_we", flags_we, 1);
        chk("R10", "pc restored", pc_out, pc);
        chk("R10", "flags restored", flags_out, fl);
      end
      @(negedge clk);
    end
    chk("R8", "busy end", busy, 0);
    chk("R8", "sp after return", sp, SP_W'(sp0 - 3));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2**SP_W; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "ack", irq_ack, 0);
    chk("R1", "stk_we", stk_we, 0);
    chk("R1", "we", {pc_we, flags_we, done}, 0);
    chk("R1", "sp", sp, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sp after release", sp, 0);

    // R2 request with global enable clear is ignored
    flags_in = 8'hFE; irq_req = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R2", "busy", busy, 0);
      chk("R2", "ack", irq_ack, 0);
      chk("R2", "stk_we", stk_we, 0);
    end
    irq_req = 1'b0;
    chk("R2", "sp", sp, 0);

    for (int i = 0; i < 4; i++) begin
      do_entry(VEC_TAB[i][39:24], VEC_TAB[i][23:16], VEC_TAB[i][15:0], '0, (i == 1));
      do_ret(SP_W'(3), VEC_TAB[i][39:24], VEC_TAB[i][23:16], 1'b0);
    end

    // R10 nesting, then R9 return priority on the outer return
    do_entry(16'h0100, 8'h01, 16'h0010, SP_W'(0), 1'b0);
    do_entry(16'h0200, 8'h03, 16'h0014, SP_W'(3), 1'b0);
    do_ret(SP_W'(6), 16'h0200, 8'h03, 1'b0);
    do_ret(SP_W'(3), 16'h0100, 8'h01, 1'b1);
    @(negedge clk);
    chk("R9", "no entry after return", busy, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule